// File: doc/BRIEF.md
# DAC Latch Load Trigger Controller

This block holds the control word and the update logic for one converter channel. A bus writes a 16-bit control word and a data word. The block then decides when the data word is copied into the output latch that feeds the converter. The trigger is one of four. The first is a plain data write. The second is a grouped write that waits until every channel in a group has had its data written. The last two are rising edges on one of two timer-compare inputs.

An enable bit gates every trigger except the plain data write. The same enable bit also freezes the upper configuration fields. Each latch update sets a flag bit in the control word. That flag, combined with an enable bit, drives an interrupt output. The reference and output-routing select bits are stored only; this block does not act on them.

The other group members report their data writes on a pulse vector. Their latches are loaded by their own copies of this block.

Top module: `dac_load_ctrl`

## Requirements
- R1: After reset, the control word, the latch, `load_pulse` and `irq` are all 0.
- R2: The load-select field is control bits 11:10. When it is 00, every data write copies the written value into the latch at the same clock edge. This happens whatever the enable bit (bit 0) holds.
- R3: When control bit 12 is 1, a load copies only data bits 7:0, and latch bits above 7 are 0. When bit 12 is 0, the full width is copied.
- R4: For load-select 01, 10 and 11, no load occurs while bit 0 is 0. A data write in that state leaves the latch unchanged.
- R5: While bit 0 is 1 before a control write, control bits 15:9 keep their old value and bits 8:0 take the written value. While bit 0 is 0, all bits are written.
- R6: For load-select 01 with the group bit (bit 3) at 0 and enable at 1, a data write loads the latch with the written value at the same edge.
- R7: For load-select 01 with bit 3 at 1 and enable at 1, the latch loads only once this channel's data write and a write pulse on every bit of `peer_wr` have all been seen. The loaded value is this channel's data. All written marks are then cleared, so the next load needs a full new round of writes.
- R8: Load-select 10 loads on a rising edge of `tmr_a`, and 11 on a rising edge of `tmr_b`. The latch shows the data register on the fourth rising clock edge after the input rises. A falling edge, a steady level or the unselected timer causes no load.
- R9: Bit 1 is set on every load and is cleared by a control write of 0 to that bit. A load in the same cycle wins over the clear. `irq` equals bit 1 AND bit 2.
- R10: `load_pulse` is 1 for exactly the one cycle in which the latch first shows a newly loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| dat_wr | input | 1 | Data word write strobe |
| dat_wdata | input | DATA_W | Data word write data |
| peer_wr | input | GROUP_N-1 | Data-write pulses from the other group members |
| tmr_a | input | 1 | First timer-compare trigger, asynchronous |
| tmr_b | input | 1 | Second timer-compare trigger, asynchronous |
| ctl_q | output | 16 | Current control word |
| latch_q | output | DATA_W | Output latch driving the converter |
| load_pulse | output | 1 | One-cycle marker of a latch load |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the grouped load. It depends on the write history of channels that the bench cannot see except through `peer_wr`. The bench writes this channel's data and then one peer, and shows that the latch has not moved. It then pulses the last peer to complete the load. A second own-data write afterwards must not load, which shows that the marks were cleared. The timer path is driven with edges placed on the falling clock edge. The latch is sampled both one cycle before and at the exact cycle the load is due, so a wrong synchronizer depth is caught.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
  localparam int CTL_W   = 16;
  localparam int B_EN    = 0;
  localparam int B_FLAG  = 1;
  localparam int B_IE    = 2;
  localparam int B_GRP   = 3;
  localparam int B_LSEL  = 10;
  localparam int B_RES   = 12;
  localparam int LOCK_LO = 9;

  typedef enum logic [1:0] {
    LD_WRITE     = 2'b00,
    LD_WRITE_GRP = 2'b01,
    LD_TMR_A     = 2'b10,
    LD_TMR_B     = 2'b11
  } ld_sel_e;
endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic rise_q
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rise_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-1:0], trig_in};
      rise_q <= sh_q[STAGES-1] & ~sh_q[STAGES];
    end
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q); // R8
endmodule

// File: rtl/dac_group_track.sv
module dac_group_track #(
  parameter int MEMBERS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               track,
  input  logic               clr,
  input  logic [MEMBERS-1:0] hit,
  output logic               full
);
  logic [MEMBERS-1:0] seen_q;

  assign full = &(seen_q | hit);

  always_ff @(posedge clk) begin
    if (rst || !track || clr) seen_q <= '0;
    else                      seen_q <= seen_q | hit;
  end

  AST_GROUP_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (seen_q == '0)); // R7
endmodule

// File: rtl/dac_ctl_reg.sv
module dac_ctl_reg
  import dac_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             set_flag,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = ctl_q;
    if (wr) begin
      nxt[LOCK_LO-1:0] = wdata[LOCK_LO-1:0];
      if (!ctl_q[B_EN]) nxt[CTL_W-1:LOCK_LO] = wdata[CTL_W-1:LOCK_LO];
    end
    if (set_flag) nxt[B_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= nxt;
  end

  AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_q[B_EN]) |-> (ctl_q[CTL_W-1:LOCK_LO] == $past(ctl_q[CTL_W-1:LOCK_LO]))); // R5
  AST_FLAG_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    set_flag |=> ctl_q[B_FLAG]); // R9
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_ctl_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int NARROW_W    = 8,
  parameter int GROUP_N     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_wr,
  input  logic [15:0]         ctl_wdata,
  input  logic                dat_wr,
  input  logic [DATA_W-1:0]   dat_wdata,
  input  logic [GROUP_N-2:0]  peer_wr,
  input  logic                tmr_a,
  input  logic                tmr_b,
  output logic [15:0]         ctl_q,
  output logic [DATA_W-1:0]   latch_q,
  output logic                load_pulse,
  output logic                irq
);
  localparam int NUM_TMR = 2;
  localparam int PAD_W   = DATA_W - NARROW_W;

  logic [DATA_W-1:0]  dat_q;
  logic [DATA_W-1:0]  src;
  logic [DATA_W-1:0]  load_val;
  logic [NUM_TMR-1:0] tmr_in;
  logic [NUM_TMR-1:0] tmr_rise;
  ld_sel_e            mode;
  logic               en, grp, res8, track, grp_full, load;

  assign tmr_in = {tmr_b, tmr_a};

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    dac_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .trig_in(tmr_in[t]),
      .rise_q (tmr_rise[t])
    );
  end

  assign mode  = ld_sel_e'(ctl_q[B_LSEL+1:B_LSEL]);
  assign en    = ctl_q[B_EN];
  assign grp   = ctl_q[B_GRP];
  assign res8  = ctl_q[B_RES];
  assign track = (mode == LD_WRITE_GRP) && grp;

  dac_group_track #(.MEMBERS(GROUP_N)) u_grp (
    .clk  (clk),
    .rst  (rst),
    .track(track),
    .clr  (load),
    .hit  ({peer_wr, dat_wr}),
    .full (grp_full)
  );

  always_comb begin
    unique case (mode)
      LD_WRITE:     load = dat_wr;
      LD_WRITE_GRP: load = en && (grp ? grp_full : dat_wr);
      LD_TMR_A:     load = en && tmr_rise[0];
      LD_TMR_B:     load = en && tmr_rise[1];
      default:      load = 1'b0;
    endcase
  end

  assign src = dat_wr ? dat_wdata : dat_q;

  generate
    if (PAD_W > 0) begin : g_narrow
      assign load_val = res8 ? {{PAD_W{1'b0}}, src[NARROW_W-1:0]} : src;
    end else begin : g_full
      assign load_val = src;
    end
  endgenerate

  dac_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr      (ctl_wr),
    .wdata   (ctl_wdata),
    .set_flag(load),
    .ctl_q   (ctl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q      <= '0;
      latch_q    <= '0;
      load_pulse <= 1'b0;
    end else begin
      if (dat_wr) dat_q <= dat_wdata;
      if (load) latch_q <= load_val;
      load_pulse <= load;
    end
  end

  assign irq = ctl_q[B_FLAG] & ctl_q[B_IE];

  AST_GATED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load_pulse && ($past(ctl_q[B_LSEL+1:B_LSEL]) != 2'b00)) |-> $past(ctl_q[B_EN])); // R4
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (load_pulse && $past(ctl_q[B_RES])) |-> (latch_q[DATA_W-1:NARROW_W] == '0)); // R3
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> ctl_q[B_FLAG]); // R10
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ctl_q[B_FLAG] && ctl_q[B_IE])); // R9
endmodule

// File: tb/test_dac_load_ctrl.sv
module test_dac_load_ctrl;
  localparam int DW = 12;
  localparam int GN = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_wr = 1'b0;
  logic [15:0]   ctl_wdata = '0;
  logic          dat_wr = 1'b0;
  logic [DW-1:0] dat_wdata = '0;
  logic [GN-2:0] peer_wr = '0;
  logic          tmr_a = 1'b0;
  logic          tmr_b = 1'b0;
  logic [15:0]   ctl_q;
  logic [DW-1:0] latch_q;
  logic          load_pulse;
  logic          irq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dac_load_ctrl #(.DATA_W(DW), .GROUP_N(GN)) i_dac_load_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .peer_wr(peer_wr),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .ctl_q(ctl_q), .latch_q(latch_q),
    .load_pulse(load_pulse), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [DW-1:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic pulse_peer(input logic [GN-2:0] v);
    @(negedge clk); peer_wr = v;
    @(negedge clk); peer_wr = '0;
  endtask

  task automatic set_cfg(input logic [15:0] v);
    wr_ctl(16'h0000);
    wr_ctl(16'h0000);
    wr_ctl(v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl_q, 16'h0000);
    chk("R1 latch", {4'h0, latch_q}, 16'h0000);
    chk("R1 pulse", {15'h0, load_pulse}, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_plain_write;
    set_cfg(16'h0000);
    wr_dat(12'hABC);
    chk("R2 latch en=0", {4'h0, latch_q}, 16'h0ABC);
    chk("R10 pulse high", {15'h0, load_pulse}, 16'h0001);
    idle(1);
    chk("R10 pulse low", {15'h0, load_pulse}, 16'h0000);
  endtask

  task automatic t_gate;
    set_cfg(16'h0400);
    wr_dat(12'h111);
    chk("R4 no load en=0", {4'h0, latch_q}, 16'h0ABC);
    wr_ctl(16'h0401);
    chk("R4 enable alone", {4'h0, latch_q}, 16'h0ABC);
    wr_dat(12'h222);
    chk("R6 ungrouped load", {4'h0, latch_q}, 16'h0222);
  endtask

  task automatic t_narrow;
    set_cfg(16'h1000);
    wr_dat(12'hFA5);
    chk("R3 narrow", {4'h0, latch_q}, 16'h00A5);
    set_cfg(16'h0000);
    wr_dat(12'hFA5);
    chk("R3 full", {4'h0, latch_q}, 16'h0FA5);
  endtask

  task automatic t_lock;
    set_cfg(16'h0001);
    wr_ctl(16'hF601);
    chk("R5 locked high", ctl_q, 16'h0001);
    wr_ctl(16'hF6F1);
    chk("R5 low writable", ctl_q, 16'h00F1);
    wr_ctl(16'h0000);
    wr_ctl(16'h1400);
    chk("R5 unlocked", ctl_q, 16'h1400);
  endtask

  task automatic t_group;
    set_cfg(16'h0409);
    wr_dat(12'h123);
    chk("R7 own only", {4'h0, latch_q}, 16'h0FA5);
    pulse_peer(2'b01);
    chk("R7 one peer", {4'h0, latch_q}, 16'h0FA5);
    pulse_peer(2'b10);
    chk("R7 all written", {4'h0, latch_q}, 16'h0123);
    wr_dat(12'h456);
    chk("R7 marks cleared", {4'h0, latch_q}, 16'h0123);
    pulse_peer(2'b11);
    chk("R7 second round", {4'h0, latch_q}, 16'h0456);
  endtask

  task automatic t_timer;
    set_cfg(16'h0801);
    wr_dat(12'h5A5);
    chk("R8 write no load", {4'h0, latch_q}, 16'h0456);
    @(negedge clk); tmr_b = 1'b1;
    idle(6);
    chk("R8 other timer", {4'h0, latch_q}, 16'h0456);
    @(negedge clk); tmr_a = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 not yet", {4'h0, latch_q}, 16'h0456);
    @(posedge clk);
    @(negedge clk);
    chk("R8 timer a load", {4'h0, latch_q}, 16'h05A5);
    wr_dat(12'h333);
    @(negedge clk); tmr_a = 1'b0;
    idle(6);
    chk("R8 falling edge", {4'h0, latch_q}, 16'h05A5);
    set_cfg(16'h0C01);
    @(negedge clk); tmr_b = 1'b0;
    idle(6);
    chk("R8 b fall", {4'h0, latch_q}, 16'h05A5);
    @(negedge clk); tmr_b = 1'b1;
    idle(6);
    chk("R8 timer b load", {4'h0, latch_q}, 16'h0333);
    @(negedge clk); tmr_b = 1'b0;
    idle(4);
  endtask

  task automatic t_irq;
    set_cfg(16'h0004);
    chk("R9 irq idle", {15'h0, irq}, 16'h0000);
    wr_dat(12'h077);
    chk("R9 flag set", {15'h0, ctl_q[1]}, 16'h0001);
    chk("R9 irq on", {15'h0, irq}, 16'h0001);
    wr_ctl(16'h0004);
    chk("R9 flag cleared", {15'h0, ctl_q[1]}, 16'h0000);
    chk("R9 irq off", {15'h0, irq}, 16'h0000);
    set_cfg(16'h0000);
    wr_dat(12'h078);
    chk("R9 masked", {15'h0, irq}, 16'h0000);
    chk("R9 flag masked", {15'h0, ctl_q[1]}, 16'h0001);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain_write();
    t_gate();
    t_narrow();
    t_lock();
    t_group();
    t_timer();
    t_irq();
    finish_run();
  end
endmodule